// File: doc/BRIEF.md
# Serial Cyclic Code Error Detector

This block checks codewords of a (15,11) cyclic code, generator x^4 + x + 1, that arrive one bit per accepted clock, highest-order coefficient first. While the bits stream in, the first eleven of them (the information part) are shifted into a holding buffer. All fifteen bits also pass through a four-cell polynomial division register. That register has the same feedback taps as the matching encoder.

Once the fifteenth bit has been taken, the block presents three things in the same cycle: the buffered information word, a one-cycle word-valid pulse, and an error flag. The error flag is the OR of the division register cells. A nonzero remainder means the received word is not a codeword, so the downstream logic should drop the word. The block only detects errors; it does not correct them.

Top module: `cyc_det`

## Requirements
- R1: While reset is held and after it is released, `wordValid`, `errFlag` and `dataOut` are all zero until the first codeword completes.
- R2: A bit is taken only in a cycle where `bitValid` is high. Cycles with `bitValid` low, whatever `bitIn` holds, do not advance the bit position or change any result.
- R3: The first eleven accepted bits of a codeword form `dataOut`. The first bit received lands in `dataOut[10]` and the eleventh in `dataOut[0]`.
- R4: The last four bits of a codeword (positions 12 to 15, the check part) never enter the information buffer. A word with errors only in its check part still shows the transmitted information bits.
- R5: `wordValid` is high for exactly one cycle, in the clock after the fifteenth bit of a codeword is accepted.
- R6: When the received 15-bit polynomial is divisible by x^4 + x + 1, `errFlag` is 0 during the `wordValid` pulse.
- R7: When the remainder of the received polynomial modulo x^4 + x + 1 is nonzero, `errFlag` is 1 during the `wordValid` pulse. This covers every single-bit and every double-bit error.
- R8: The division register starts from zero at the first bit of every codeword, so the result for a word does not depend on the words before it, including back-to-back words with no idle cycle between them.
- R9: `dataOut` and `errFlag` hold their values from one `wordValid` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Received code bit, highest-order coefficient first |
| bitValid | input | 1 | Qualifies `bitIn` in this cycle |
| dataOut | output | 11 (K) | Buffered information word of the last completed codeword |
| wordValid | output | 1 | One-cycle pulse marking a completed codeword |
| errFlag | output | 1 | Nonzero remainder of the last completed codeword |

## Verification
The bench builds the block with its default parameters: length 15, 11 information bits and generator taps 0x3 (x^4 + x + 1). With these defaults the bench can corrupt every one of the fifteen bit positions singly, and so every single-error remainder is produced. It also applies double errors and errors confined to the check part, and sends clean words straight after corrupted ones. Random idle gaps carrying garbage on `bitIn` are inserted between bits. A scoreboard compares each output pulse against the remainder that the bench computes itself by long division.

// File: rtl/cyc_det_pkg.sv
package cyc_det_pkg;

  // Strobes from sequencing control to the datapath, valid for one cycle.
  typedef struct packed {
    logic take;   // a bit is accepted this cycle
    logic first;  // accepted bit is the first of a codeword
    logic bufEn;  // accepted bit belongs to the information part
    logic last;   // accepted bit completes the codeword
  } ctlStrobes_t;

endpackage

// File: rtl/cyc_det_ctrl.sv
module cyc_det_ctrl
  import cyc_det_pkg::*;
#(
  parameter int N = 15,
  parameter int K = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitValid,
  output ctlStrobes_t ctl
);

  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST_POS = CW'(N - 1);
  localparam logic [CW-1:0] INFO_END = CW'(K);

  logic [CW-1:0] bitPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitPos <= '0;
    end else if (bitValid) begin
      bitPos <= (bitPos == LAST_POS) ? '0 : bitPos + 1'b1;
    end
  end

  always_comb begin
    ctl.take  = bitValid;
    ctl.first = bitValid && (bitPos == '0);
    ctl.bufEn = bitValid && (bitPos < INFO_END);
    ctl.last  = bitValid && (bitPos == LAST_POS);
  end

  // R2: the bit position never leaves the codeword range
  p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitPos <= LAST_POS);

  // R2: idle cycles leave the bit position untouched
  p_idle_freeze_r2: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> $stable(bitPos));

  // R8: after a completed word the next accepted bit starts a new one
  p_wrap_after_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.last |=> (bitPos == '0));

endmodule

// File: rtl/cyc_det_dp.sv
module cyc_det_dp
  import cyc_det_pkg::*;
#(
  parameter int K = 11,
  parameter int R = 4,
  parameter logic [R-1:0] POLY = 4'h3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitIn,
  input  ctlStrobes_t  ctl,
  output logic [K-1:0] dataOut,
  output logic         wordValid,
  output logic         errFlag
);

  logic [R-1:0] remReg;
  logic [R-1:0] remBase;
  logic [R-1:0] remNext;
  logic         feedBack;
  logic [K-1:0] infoBuf;

  // Division register seeded from zero on the first bit of each word.
  assign remBase  = ctl.first ? '0 : remReg;
  assign feedBack = remBase[R-1];

  for (genvar g = 0; g < R; g++) begin : g_cell
    if (g == 0) begin : g_head
      assign remNext[g] = bitIn ^ (feedBack & POLY[g]);
    end else begin : g_tail
      assign remNext[g] = remBase[g-1] ^ (feedBack & POLY[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg    <= '0;
      infoBuf   <= '0;
      dataOut   <= '0;
      wordValid <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (ctl.take) begin
        remReg <= remNext;
      end
      if (ctl.bufEn) begin
        infoBuf <= {infoBuf[K-2:0], bitIn};
      end
      wordValid <= ctl.last;
      if (ctl.last) begin
        dataOut <= infoBuf;
        errFlag <= |remNext;
      end
    end
  end

  // R5: the word-valid pulse lasts a single cycle
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R9: results are held between completed words
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.last |=> ($stable(dataOut) && $stable(errFlag)));

  // R4: check-part bits leave the information buffer untouched
  p_buf_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.take && !ctl.bufEn) |=> $stable(infoBuf));

  // R2: without an accepted bit the remainder does not move
  p_rem_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.take |=> $stable(remReg));

endmodule

// File: rtl/cyc_det.sv
module cyc_det
  import cyc_det_pkg::*;
#(
  parameter int N    = 15,
  parameter int K    = 11,
  parameter int POLY = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitIn,
  input  logic         bitValid,
  output logic [K-1:0] dataOut,
  output logic         wordValid,
  output logic         errFlag
);

  localparam int R = N - K;
  localparam logic [R-1:0] POLY_TAPS = R'(POLY);

  ctlStrobes_t ctl;

  cyc_det_ctrl #(.N(N), .K(K)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitValid (bitValid),
    .ctl      (ctl)
  );

  cyc_det_dp #(.K(K), .R(R), .POLY(POLY_TAPS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .bitIn     (bitIn),
    .ctl       (ctl),
    .dataOut   (dataOut),
    .wordValid (wordValid),
    .errFlag   (errFlag)
  );

endmodule

// File: tb/cyc_det_tb.sv
module cyc_det_tb;

  localparam int N = 15;
  localparam int K = 11;
  localparam int R = N - K;
  localparam logic [R:0] GEN = 5'b10011;  // x^4 + x + 1

  logic clk = 1'b0;
  logic rstN;
  logic bitIn;
  logic bitValid;
  logic [K-1:0] dataOut;
  logic wordValid;
  logic errFlag;

  always #4 clk = ~clk;  // 125 MHz

  cyc_det u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .bitIn     (bitIn),
    .bitValid  (bitValid),
    .dataOut   (dataOut),
    .wordValid (wordValid),
    .errFlag   (errFlag)
  );

  typedef struct {
    logic [K-1:0] data;
    logic         err;
    string        tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  bit monOn = 1'b0;
  bit seenWord = 1'b0;
  bit prevValid = 1'b0;
  logic [K-1:0] heldData;
  logic heldErr;

  function automatic logic [R-1:0] modGen(logic [N-1:0] v);
    for (int i = N - 1; i >= R; i--) begin
      if (v[i]) v = v ^ (N'(GEN) << (i - R));
    end
    return v[R-1:0];
  endfunction

  function automatic logic [N-1:0] encode(logic [K-1:0] info);
    logic [N-1:0] v;
    v = {info, {R{1'b0}}};
    return v | {{K{1'b0}}, modGen(v)};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Driver: pushes the expected result, then sends bits with idle gaps.
  task automatic sendWord(logic [K-1:0] info, logic [N-1:0] errMask,
                          string tag, bit gaps);
    logic [N-1:0] rx;
    expItem_t e;
    rx = encode(info) ^ errMask;
    e.data = rx[N-1:R];
    e.err  = (modGen(rx) != '0);
    e.tag  = tag;
    expQ.push_back(e);
    for (int i = N - 1; i >= 0; i--) begin
      @(negedge clk);
      bitValid = 1'b1;
      bitIn    = rx[i];
      if (gaps) begin
        int idle;
        idle = $urandom_range(0, 2);
        for (int j = 0; j < idle; j++) begin
          @(negedge clk);
          bitValid = 1'b0;
          bitIn    = 1'($urandom);  // garbage that must be ignored (R2)
        end
      end
    end
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (wordValid) begin
        check(!prevValid, "R5", "pulse longer than one cycle", 1, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R5", "unexpected wordValid", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(dataOut == e.data, "R3/R4", {"data ", e.tag},
                int'(dataOut), int'(e.data));
          check(errFlag == e.err, e.err ? "R7" : "R6", {"err ", e.tag},
                int'(errFlag), int'(e.err));
        end
        heldData = dataOut;
        heldErr  = errFlag;
        seenWord = 1'b1;
      end else if (seenWord) begin
        check(dataOut == heldData && errFlag == heldErr, "R9",
              "outputs changed between pulses",
              int'({errFlag, dataOut}), int'({heldErr, heldData}));
      end
      prevValid = wordValid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 1, 0);
    summary();
  end

  initial begin
    rstN = 1'b0;
    bitIn = 1'b0;
    bitValid = 1'b0;
    repeat (3) @(negedge clk);
    check(wordValid == 1'b0, "R1", "wordValid in reset", int'(wordValid), 0);
    check(errFlag == 1'b0, "R1", "errFlag in reset", int'(errFlag), 0);
    check(dataOut == '0, "R1", "dataOut in reset", int'(dataOut), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(wordValid == 1'b0 && dataOut == '0 && errFlag == 1'b0, "R1",
          "outputs after reset", int'({wordValid, errFlag, dataOut}), 0);
    monOn = 1'b1;

    // R6: clean words of several patterns
    sendWord(11'h000, '0, "clean zero R6", 1'b0);
    sendWord(11'h7FF, '0, "clean ones R6", 1'b1);
    sendWord(11'h5A3, '0, "clean mixed R6", 1'b1);
    // R7: every single-bit error position
    for (int p = 0; p < N; p++) begin
      sendWord(11'h2C7, N'(1) << p, "single error R7", 1'b1);
    end
    // R4: errors only in the check part
    sendWord(11'h1B4, 15'h0005, "check-part error R4", 1'b1);
    // R7: double errors
    sendWord(11'h3E1, 15'h4010, "double error R7", 1'b1);
    sendWord(11'h0F0, 15'h0003, "adjacent double R7", 1'b0);
    // R8: back-to-back, error word then clean word without gaps
    sendWord(11'h555, 15'h0800, "error before clean R8", 1'b0);
    sendWord(11'h555, '0, "clean after error R8", 1'b0);
    sendWord(11'h2AA, 15'h0001, "error R8", 1'b0);
    sendWord(11'h123, '0, "clean R8", 1'b1);
    @(negedge clk);
    bitValid = 1'b0;

    for (int w = 0; w < 50 && expQ.size() != 0; w++) @(negedge clk);
    check(expQ.size() == 0, "R5", "missing results", expQ.size(), 0);
    repeat (5) @(negedge clk);
    summary();
  end

endmodule